// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Meter

This block measures how fast the local peripheral clock runs by counting its cycles across a window set by a slow reference clock. One of three reference inputs is chosen by a two-bit select: a 16 kHz oscillator, a 32 kHz oscillator, or an external audio word-select clock. Software programs an 8-bit period field M and raises a start bit. The block then counts peripheral clock cycles over M+1 reference periods. It latches a 16-bit result and raises a done flag. Software turns the count into a frequency.

The start bit is a level, not a pulse. While it is 1, one measurement runs to completion and the result is held. Clearing it returns the block to its idle, cleared state. The reference is brought into the peripheral clock domain through a synchronizer, and its rising edges open and close the window. The select and period fields are captured while start is 0. Changes to them made during a measurement wait for the next start.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, `done` is 0 and `count` is 0.
- R2: The reference select code chooses the source: 2'b00 picks `ref_slow`, 2'b01 picks `ref_fast`, and 2'b10 or 2'b11 picks `ref_ext`.
- R3: Let P be the reference period in peripheral clock cycles. With a steady P, the final `count` equals (M+1)*P, where M is the value of `periods` when start rose.
- R4: `done` is 0 from the rise of `start` until the window closes. It then becomes 1 and stays 1 while `start` stays 1.
- R5: One cycle after `start` is 0, `done` is 0 and `count` is 0.
- R6: The counter saturates at 16'hFFFF instead of wrapping. A window longer than 65535 cycles reads 16'hFFFF.
- R7: Changes to `ref_sel` or `periods` while `start` is 1 have no effect on the running measurement.
- R8: Once `done` is 1, `count` holds steady while further reference edges arrive, for as long as `start` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock, the clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | 1 runs a measurement; 0 disables and clears the block |
| ref_sel | input | 2 | Reference select code |
| periods | input | 8 | Window length M; the window is M+1 reference periods |
| ref_slow | input | 1 | 16 kHz oscillator reference |
| ref_fast | input | 1 | 32 kHz oscillator reference |
| ref_ext | input | 1 | External word-select reference |
| done | output | 1 | Measurement complete |
| count | output | 16 | Peripheral cycles counted in the window |

## Verification
Counter saturation and the window-closing reference edge can meet: on a long window the counter reaches 16'hFFFF well before the closing edge. The close must still set `done` without disturbing the saturated value. The bench provokes this with a 260-cycle external reference and M=255. It judges the result against the arithmetic limit min((M+1)*P, 65535), and M=250 gives the matching unsaturated case just below the limit. A second meeting point is a select or period change during a window. The bench judges it by requiring the count from the sources captured at start.

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int CNT_W  = 16,
  parameter int PER_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       ref_sel,
  input  logic [PER_W-1:0] periods,
  input  logic             ref_slow,
  input  logic             ref_fast,
  input  logic             ref_ext,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN, ST_FIN} st_t;

  st_t              st;
  logic [1:0]       sel_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] edges;
  logic [CNT_W-1:0] cnt;
  logic [SYNC_N:0]  sh;
  logic             ref_mux, ref_rise;

  assign ref_mux  = sel_q[1] ? ref_ext : (sel_q[0] ? ref_fast : ref_slow);
  assign ref_rise = sh[SYNC_N-1] & ~sh[SYNC_N];
  assign done     = (st == ST_FIN);
  assign count    = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      per_q <= '0;
    end else if (!start) begin
      sel_q <= ref_sel;
      per_q <= periods;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_N-1:0], ref_mux};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      edges <= '0;
    end else if (!start) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      edges <= '0;
    end else begin
      case (st)
        ST_IDLE: st <= ST_ARM;
        ST_ARM: if (ref_rise) begin
          st    <= ST_RUN;
          cnt   <= '0;
          edges <= '0;
        end
        ST_RUN: begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (ref_rise) begin
            if (edges == per_q) st <= ST_FIN;
            else                edges <= edges + 1'b1;
          end
        end
        default: st <= ST_FIN;
      endcase
    end
  end

  // R5
  clear_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && count == '0));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  // R8
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> $stable(count));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!start || count >= $past(count)));

  // R4
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> !$past(start));
endmodule

// File: tb/clk_freq_meter_test.sv
module clk_freq_meter_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] ref_sel = 0;
  logic [7:0] periods = 0;
  logic ref_slow = 0, ref_fast = 0, ref_ext = 0;
  logic done;
  logic [15:0] count;
  int total = 0, bad = 0;
  int he = 6;

  clk_freq_meter uut (.clk(clk), .rst_n(rst_n), .start(start), .ref_sel(ref_sel),
    .periods(periods), .ref_slow(ref_slow), .ref_fast(ref_fast), .ref_ext(ref_ext),
    .done(done), .count(count));

  always #4 clk = ~clk;

  initial forever begin repeat (8) @(negedge clk); ref_slow = ~ref_slow; end
  initial forever begin repeat (4) @(negedge clk); ref_fast = ~ref_fast; end
  initial forever begin repeat (he) @(negedge clk); ref_ext = ~ref_ext; end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 90000) begin @(negedge clk); t++; end
  endtask

  task automatic measure(input logic [1:0] sel, input int m, input int p);
    int exp;
    exp = (m + 1) * p;
    if (exp > 65535) exp = 65535;
    @(negedge clk);
    start = 0; ref_sel = sel; periods = m[7:0];
    repeat (3) @(negedge clk);
    start = 1;
    repeat (2) @(negedge clk);
    chk(done == 0, "R4 done low while running", done, 0);
    wait_done();
    @(negedge clk);
    chk(done == 1, "R4 done set", done, 1);
    chk(count == exp[15:0], (exp == 65535) ? "R6 saturated count" : "R2/R3 count", count, exp);
    repeat (2 * p) @(negedge clk);
    chk(done == 1 && count == exp[15:0], "R8 count held after done", count, exp);
    start = 0;
    @(negedge clk);
    chk(done == 0 && count == 0, "R5 stop clears", count, 0);
  endtask

  initial begin
    int mv[5] = '{0, 1, 2, 5, 9};
    int pv[4] = '{16, 8, 12, 12};
    repeat (3) @(negedge clk);
    chk(done == 0 && count == 0, "R1 reset state", count, 0);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && count == 0, "R1 after release", count, 0);

    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 5; i++)
        measure(s[1:0], mv[i], pv[s]);

    // R7: change select and period in mid-window
    @(negedge clk);
    start = 0; ref_sel = 2'b01; periods = 8'd3;
    repeat (3) @(negedge clk);
    start = 1;
    repeat (20) @(negedge clk);
    ref_sel = 2'b00; periods = 8'd9;
    wait_done();
    @(negedge clk);
    chk(count == 32, "R7 mid-run change ignored", count, 32);
    start = 0;
    @(negedge clk);
    chk(done == 0 && count == 0, "R5 stop clears", count, 0);

    he = 130;
    repeat (300) @(negedge clk);
    measure(2'b11, 250, 260);
    measure(2'b10, 255, 260);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule